// File: doc/BRIEF.md
# Bus-Attached GPIO Port with Set/Clear Output Control

This block is a 32-pin general-purpose I/O port that a host reaches as a Wishbone classic slave. The host programs each pin as an input or an output and reads back the synchronized pin levels. It changes the output levels in one of three ways: it can load a whole word, set selected bits, or clear selected bits. None of the three output registers can be read back.

The block keeps no copy of the whole-word output register. It passes the raw bus write data straight to the device side and marks each write to that register with a strobe that lasts one clock. An internal output latch takes the full word on that strobe. Writes to the set and clear registers OR or AND-NOT their data into the latch, so a driver can change single pins without a read-modify-write cycle. Each access is acknowledged one clock after the request is seen. The acknowledge then drops for one clock, so a request that stays asserted is served only once per acknowledge.

Top module: `pin_port_wb`

## Requirements
- R1: While reset is asserted and after it is released, wb_ack_o, wr_pulse_o, pin_oe_o and pin_out_o are all zero, so every pin starts as an input driving low.
- R2: A write to word address 0 loads the direction word. pin_oe_o shows it from the cycle after the acknowledging edge (bit = 1 means output, bit = 0 means input), and a read of address 0 returns it.
- R3: A read of word address 1 returns the pin_i levels as sampled through a two-flop synchronizer. A level applied just before the accepting edge is not yet visible, but it is visible two edges later. Writes to address 1 change nothing.
- R4: wr_data_o always equals wb_dat_i. A write to word address 2 raises wr_pulse_o for exactly one cycle, in the same cycle as its acknowledge, and loads the full word into pin_out_o.
- R5: A write to word address 4 sets to 1 every pin_out_o bit whose data bit is 1 and leaves all other bits unchanged.
- R6: A write to word address 5 clears to 0 every pin_out_o bit whose data bit is 1 and leaves all other bits unchanged.
- R7: Reads of word addresses 2, 4 and 5 return zero.
- R8: Word addresses 3, 6 and 7 read back zero, and writes to them leave pin_out_o, pin_oe_o and wr_pulse_o unchanged.
- R9: wb_ack_o rises in the cycle after wb_cyc_i and wb_stb_i are seen high together and is low in the following cycle. A request held high is therefore acknowledged on every other cycle. Without a request, wb_ack_o stays low.
- R10: pin_out_o changes only after a write to address 2, 4 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADR_W (3) | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid while wb_ack_o is high |
| wb_ack_o | output | 1 | Acknowledge |
| pin_i | input | 32 | Raw pin levels, asynchronous |
| pin_oe_o | output | 32 | Per-pin output enable (direction word) |
| pin_out_o | output | 32 | Output latch value |
| wr_data_o | output | 32 | Raw bus write data for the whole-word output register |
| wr_pulse_o | output | 1 | One-cycle strobe on a write to address 2 |

## Verification
On every cycle the assertions check the acknowledge rhythm, that the strobe lasts one cycle and coincides with the acknowledge, and that each synchronizer stage follows the stage before it. They also check that a direction write reaches pin_oe_o. For load, set and clear events they check the latch arithmetic, and they check that the latch stays unchanged when no such event occurs. Some properties are visible only from the bench's scenarios. These are the read-back contents of each address: zero for the write-only and unmapped words, and the exact moment a new pin level becomes readable through the synchronizer. They also include the alternating acknowledge under a held strobe and the return of all outputs to zero after a late reset.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Word addresses; the set/clear pair sits on a 4-aligned boundary.
  localparam int unsigned ADR_DIR = 0;
  localparam int unsigned ADR_PSR = 1;
  localparam int unsigned ADR_OUT = 2;
  localparam int unsigned ADR_SET = 4;
  localparam int unsigned ADR_CLR = 5;

  function automatic word_t set_bits(word_t cur, word_t mask);
    return cur | mask;
  endfunction

  function automatic word_t clr_bits(word_t cur, word_t mask);
    return cur & ~mask;
  endfunction
endpackage

// File: rtl/pin_port_bus.sv
module pin_port_bus
  import pin_port_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          cyc_i,
  input  logic          stb_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  word_t         dir_i,
  input  word_t         psr_i,
  output logic          ack_o,
  output word_t         dat_o,
  output logic          ev_dir_o,
  output logic          ev_load_o,
  output logic          ev_set_o,
  output logic          ev_clr_o
);
  logic  take, wr, rd;
  logic  hit_dir, hit_psr, hit_out, hit_set, hit_clr, hit_wo, hit_none;
  word_t rd_word;

  assign take     = cyc_i & stb_i & ~ack_o;
  assign wr       = take & we_i;
  assign rd       = take & ~we_i;
  assign hit_dir  = adr_i == AW'(ADR_DIR);
  assign hit_psr  = adr_i == AW'(ADR_PSR);
  assign hit_out  = adr_i == AW'(ADR_OUT);
  assign hit_set  = adr_i == AW'(ADR_SET);
  assign hit_clr  = adr_i == AW'(ADR_CLR);
  assign hit_wo   = hit_out | hit_set | hit_clr;
  assign hit_none = ~(hit_dir | hit_psr | hit_wo);

  assign ev_dir_o  = wr & hit_dir;
  assign ev_load_o = wr & hit_out;
  assign ev_set_o  = wr & hit_set;
  assign ev_clr_o  = wr & hit_clr;

  always_comb begin
    rd_word = '0;
    if (hit_dir) rd_word = dir_i;
    else if (hit_psr) rd_word = psr_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ack_o <= 1'b0;
      dat_o <= '0;
    end else begin
      ack_o <= take;
      if (rd) dat_o <= rd_word;
    end
  end

  // R9
  ack_after_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !$past(rst_i)) |-> $past(cyc_i && stb_i));
  // R9
  ack_once_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |=> !ack_o);
  // R7
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd && hit_wo) |=> dat_o == '0);
  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd && hit_none) |=> dat_o == '0);
endmodule

// File: rtl/pin_port_sync.sv
module pin_port_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) st[0] <= '0;
    else       st[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) st[k] <= '0;
      else       st[k] <= st[k-1];
    end
    // R3
    stage_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> st[k] == $past(st[k-1]));
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/pin_port_latch.sv
module pin_port_latch
  import pin_port_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  ev_load_i,
  input  logic  ev_set_i,
  input  logic  ev_clr_i,
  input  word_t dat_i,
  output word_t q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)          q_o <= '0;
    else if (ev_load_i) q_o <= dat_i;
    else if (ev_set_i)  q_o <= set_bits(q_o, dat_i);
    else if (ev_clr_i)  q_o <= clr_bits(q_o, dat_i);
  end

  // R4
  load_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_load_i |=> q_o == $past(dat_i));
  // R5
  set_bits_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_set_i |=> ((q_o & $past(dat_i)) == $past(dat_i))
              && ((q_o & ~$past(dat_i)) == ($past(q_o) & ~$past(dat_i))));
  // R6
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_clr_i |=> ((q_o & $past(dat_i)) == '0)
              && ((q_o & ~$past(dat_i)) == ($past(q_o) & ~$past(dat_i))));
  // R10
  latch_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(ev_load_i || ev_set_i || ev_clr_i) |=> $stable(q_o));
endmodule

// File: rtl/pin_port_wb.sv
module pin_port_wb
  import pin_port_pkg::*;
#(
  parameter int ADR_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [31:0]      wb_dat_i,
  output logic [31:0]      wb_dat_o,
  output logic             wb_ack_o,
  input  logic [31:0]      pin_i,
  output logic [31:0]      pin_oe_o,
  output logic [31:0]      pin_out_o,
  output logic [31:0]      wr_data_o,
  output logic             wr_pulse_o
);
  word_t dir_q, psr_w;
  logic  ev_dir, ev_load, ev_set, ev_clr;

  pin_port_bus #(.AW(ADR_W)) u_bus (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cyc_i    (wb_cyc_i),
    .stb_i    (wb_stb_i),
    .we_i     (wb_we_i),
    .adr_i    (wb_adr_i),
    .dir_i    (dir_q),
    .psr_i    (psr_w),
    .ack_o    (wb_ack_o),
    .dat_o    (wb_dat_o),
    .ev_dir_o (ev_dir),
    .ev_load_o(ev_load),
    .ev_set_o (ev_set),
    .ev_clr_o (ev_clr)
  );

  pin_port_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .d_i  (pin_i),
    .q_o  (psr_w)
  );

  pin_port_latch u_latch (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .ev_load_i(ev_load),
    .ev_set_i (ev_set),
    .ev_clr_i (ev_clr),
    .dat_i    (wb_dat_i),
    .q_o      (pin_out_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dir_q      <= '0;
      wr_pulse_o <= 1'b0;
    end else begin
      if (ev_dir) dir_q <= wb_dat_i;
      wr_pulse_o <= ev_load;
    end
  end

  assign pin_oe_o  = dir_q;
  assign wr_data_o = wb_dat_i;

  // R2
  dir_reaches_oe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_dir |=> pin_oe_o == $past(wb_dat_i));
  // R4
  pulse_with_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_pulse_o |-> wb_ack_o);
  // R4
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_pulse_o |=> !wr_pulse_o);
endmodule

// File: tb/tb_pin_port_wb.sv
module tb_pin_port_wb;
  localparam int CLK_P = 10;
  localparam int NV    = 14;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [2:0]  adr = '0;
  logic [31:0] wdat = '0, pins = '0;
  logic [31:0] rdat, oe, pout, wrd;
  logic        ack, pulse;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pin_port_wb dut (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .pin_i(pins), .pin_oe_o(oe), .pin_out_o(pout), .wr_data_o(wrd),
    .wr_pulse_o(pulse)
  );

  // Vector fields: we | adr | write data | expected read | expected pin_out_o | expected pin_oe_o
  localparam logic [131:0] VEC [NV] = '{
    {1'b1, 3'd0, 32'hFFFF0000, 32'h0,        32'h0,        32'hFFFF0000}, // R2
    {1'b0, 3'd0, 32'h0,        32'hFFFF0000, 32'h0,        32'hFFFF0000}, // R2
    {1'b1, 3'd2, 32'h12345678, 32'h0,        32'h12345678, 32'hFFFF0000}, // R4
    {1'b1, 3'd4, 32'h000000F0, 32'h0,        32'h123456F8, 32'hFFFF0000}, // R5
    {1'b1, 3'd5, 32'h10000008, 32'h0,        32'h023456F0, 32'hFFFF0000}, // R6
    {1'b0, 3'd2, 32'h0,        32'h0,        32'h023456F0, 32'hFFFF0000}, // R7
    {1'b0, 3'd4, 32'h0,        32'h0,        32'h023456F0, 32'hFFFF0000}, // R7
    {1'b0, 3'd5, 32'h0,        32'h0,        32'h023456F0, 32'hFFFF0000}, // R7
    {1'b1, 3'd3, 32'hFFFFFFFF, 32'h0,        32'h023456F0, 32'hFFFF0000}, // R8
    {1'b0, 3'd3, 32'h0,        32'h0,        32'h023456F0, 32'hFFFF0000}, // R8
    {1'b1, 3'd6, 32'hFFFFFFFF, 32'h0,        32'h023456F0, 32'hFFFF0000}, // R8
    {1'b1, 3'd7, 32'h00000000, 32'h0,        32'h023456F0, 32'hFFFF0000}, // R8
    {1'b1, 3'd1, 32'hDEADBEEF, 32'h0,        32'h023456F0, 32'hFFFF0000}, // R3
    {1'b1, 3'd0, 32'h0000FFFF, 32'h0,        32'h023456F0, 32'h0000FFFF}  // R2
  };
  localparam int TAG [NV] = '{2, 2, 4, 5, 6, 7, 7, 7, 8, 8, 8, 8, 3, 2};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: drive at negedge, accept at the next edge, sample 1 time unit after it.
  task automatic access(input logic w, input logic [2:0] a, input logic [31:0] d,
                        output logic [31:0] rd_o, output logic ack_o, output logic pls_o,
                        output logic [31:0] wrd_o, output logic ack_pre);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    #1 ack_pre = ack;
    @(posedge clk);
    #1;
    rd_o = rdat; ack_o = ack; pls_o = pulse; wrd_o = wrd;
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, wv; logic a, p, apre;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs during reset
    chk("R1 ack", 32'(ack), 0); chk("R1 oe", oe, 0); chk("R1 out", pout, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 pulse", 32'(pulse), 0); chk("R1 out post", pout, 0);

    for (int i = 0; i < NV; i++) begin
      logic [131:0] v;
      v = VEC[i];
      access(v[131], v[130:128], v[127:96], r, a, p, wv, apre);
      chk($sformatf("R%0d ack", TAG[i]), 32'(a), 1);
      if (!v[131]) chk($sformatf("R%0d read", TAG[i]), r, v[95:64]);
      chk($sformatf("R%0d pin_out", TAG[i]), pout, v[63:32]);
      chk($sformatf("R%0d pin_oe", TAG[i]), oe, v[31:0]);
      // R4 / R8: strobe only for address 2 writes
      chk("R4 pulse", 32'(p), 32'(v[131] && v[130:128] == 3'd2));
      chk("R4 passthru", wv, v[127:96]);
    end

    // R4: strobe gone the next cycle
    access(1'b1, 3'd2, 32'hA5A5_0F0F, r, a, p, wv, apre);
    chk("R4 strobe", 32'(p), 1);
    chk("R4 load", pout, 32'hA5A5_0F0F);
    @(posedge clk); #1;
    chk("R4 strobe one cycle", 32'(pulse), 0);
    chk("R10 idle out", pout, 32'hA5A5_0F0F);

    // R9: ack low before accept, high after, then low; no request -> no ack
    access(1'b0, 3'd0, 32'h0, r, a, p, wv, apre);
    chk("R9 ack before", 32'(apre), 0);
    chk("R9 ack after", 32'(a), 1);
    @(posedge clk); #1;
    chk("R9 idle ack", 32'(ack), 0);

    // R9: held request gets ack on alternate cycles
    @(negedge clk); cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 3'd0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk("R9 alternate", 32'(ack), 32'(k % 2 == 0));
    end
    @(negedge clk); cyc = 1'b0; stb = 1'b0;

    // R9: strobe without cycle gets no ack
    @(negedge clk); stb = 1'b1; cyc = 1'b0;
    @(posedge clk); #1;
    chk("R9 no cyc", 32'(ack), 0);
    @(negedge clk); stb = 1'b0;

    // R3: synchronizer latency
    @(negedge clk); pins = 32'h5A5A_C3C3;
    access(1'b0, 3'd1, 32'h0, r, a, p, wv, apre);
    chk("R3 not yet", r, 32'h0);
    repeat (2) @(posedge clk);
    access(1'b0, 3'd1, 32'h0, r, a, p, wv, apre);
    chk("R3 synced", r, 32'h5A5A_C3C3);
    access(1'b1, 3'd1, 32'hFFFF_FFFF, r, a, p, wv, apre);
    access(1'b0, 3'd1, 32'h0, r, a, p, wv, apre);
    chk("R3 write ignored", r, 32'h5A5A_C3C3);

    // R1: late reset clears everything
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset oe", oe, 0); chk("R1 reset out", pout, 0);
    @(negedge clk); rst = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule